// File: doc/BRIEF.md
# Static Segment Slot Sequencer

This block paces the time-triggered part of each communication cycle. A pulse on `cycle_start` begins the segment at slot 1. The block then counts a configured number of equal-length slots, each lasting a configured number of macroticks. Inside every slot, the block waits a configured offset from the slot start, called the action point. At that point it asks the host whether a frame is waiting for the current slot and the current cycle number. If one is waiting, it emits a single transmit strobe that carries the slot ID.

A slot with nothing to send still runs its full length, and the bus stays quiet for that slot. When the count passes the last configured slot, the block pulses `seg_done`. It then ignores macroticks until the next cycle start, which hands control to whatever follows the static segment.

The host answers the ownership query combinationally. The block presents `query_slot` and `query_cycle`, and the host returns `query_pending` in the same clock. This lets one slot carry different messages in different cycles.

The transmit strobe is a one-clock data beat. It has no ready signal, because a time-division slot cannot be delayed: the consumer must accept the beat in the clock it appears, and there is no back-pressure.

All pulse outputs are registered. They appear one clock after the macrotick edge that causes them.

Top module: `static_slot_seq`

## Requirements
- R1: After reset, `slot_cnt` is 0 and `tx_strobe`, `slot_bound` and `seg_done` are low. Macroticks before the first `cycle_start` produce no pulse and leave `slot_cnt` at 0.
- R2: A `cycle_start` pulse sets `slot_cnt` to 1 in the next clock, restarts the slot timer and latches `cycle_num`. This holds even in the middle of a segment. A macrotick in the same clock as `cycle_start` is ignored.
- R3: Each slot ends on its `cfg_slot_len`-th macrotick. The clock after that tick shows a one-clock `slot_bound` pulse, and `slot_cnt` has risen by one.
- R4: On the macrotick where the count inside the slot equals `cfg_ap_off` (that is, tick `cfg_ap_off`+1 of the slot, counting the first as 1), the block checks `query_pending`. If it is high, the next clock shows a one-clock `tx_strobe` with `tx_slot_id` equal to the current slot.
- R5: If `query_pending` is low at the action point, no strobe is produced, and the slot still lasts `cfg_slot_len` macroticks.
- R6: The boundary after which `slot_cnt` would exceed `cfg_num_slots` raises `seg_done` in the same clock as that `slot_bound`, leaving `slot_cnt` at `cfg_num_slots`+1. Further macroticks produce no pulse and do not change `slot_cnt` until the next `cycle_start`.
- R7: `cfg_err` is high whenever `cfg_ap_off` >= `cfg_slot_len`. While it is high, no strobe is produced, but slots and boundaries run as normal.
- R8: At most one `tx_strobe` occurs per slot, and each strobe lasts exactly one clock. This includes an action point that falls on the slot's last macrotick.
- R9: `query_slot` equals `slot_cnt`, and `query_cycle` equals the latched cycle number. Ownership can therefore differ for the same slot in different cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-clock pulse that begins a cycle |
| cycle_num | input | CYC_W | Cycle number, sampled on `cycle_start` |
| mt_tick | input | 1 | Macrotick strobe, one clock per macrotick |
| cfg_num_slots | input | SLOT_W | Number of static slots |
| cfg_slot_len | input | MT_W | Slot length in macroticks |
| cfg_ap_off | input | MT_W | Action point offset in macroticks |
| query_slot | output | SLOT_W | Slot being queried for ownership |
| query_cycle | output | CYC_W | Cycle being queried for ownership |
| query_pending | input | 1 | Host has a frame for the queried slot and cycle |
| slot_cnt | output | SLOT_W | Current slot number, host visible |
| tx_strobe | output | 1 | One-clock transmit beat, no ready |
| tx_slot_id | output | SLOT_W | Slot ID carried with `tx_strobe` |
| slot_bound | output | 1 | One-clock slot-boundary pulse |
| seg_done | output | 1 | One-clock end-of-segment pulse |
| cfg_err | output | 1 | Action point offset not below slot length |

## Verification
The bench builds the block with its default widths: 6-bit slot, 8-bit macrotick and 6-bit cycle fields. It configures five slots with lengths of 3 and 4 macroticks. These short slots bring several corners within reach in a few hundred clocks: an action point on the first tick of a slot, an action point on the last tick where strobe and boundary coincide, an offset equal to the slot length, and a restart in the middle of a segment. The host table gives one slot to cycle 2 only, so the same slot is checked both transmitting and silent.

// File: rtl/static_slot_seq_pkg.sv
package static_slot_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_STATIC   = 2'd1,
    PH_FINISHED = 2'd2
  } seg_phase_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int MT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            enable,
  input  logic            tick,
  input  logic [MT_W-1:0] slot_len,
  input  logic [MT_W-1:0] ap_off,
  output logic            at_ap,
  output logic            at_end
);
  localparam logic [MT_W-1:0] ONE = MT_W'(1);

  logic [MT_W-1:0] mt_cnt;
  logic            live;

  assign live   = enable & tick & ~restart;
  assign at_ap  = live & (mt_cnt == ap_off);
  assign at_end = live & (mt_cnt == slot_len - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      mt_cnt <= '0;
    end else if (at_end) begin
      mt_cnt <= '0;
    end else if (live) begin
      mt_cnt <= mt_cnt + ONE;
    end
  end
endmodule

// File: rtl/tx_gate.sv
module tx_gate #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              tx_strobe,
  output logic [SLOT_W-1:0] tx_slot_id
);
  logic sent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent       <= 1'b0;
      tx_strobe  <= 1'b0;
      tx_slot_id <= '0;
    end else begin
      tx_strobe <= fire & ~sent;
      if (fire && !sent) begin
        tx_slot_id <= slot_in;
      end
      sent <= clear ? 1'b0 : (sent | fire);
    end
  end
endmodule

// File: rtl/static_slot_seq.sv
module static_slot_seq
  import static_slot_seq_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int MT_W   = 8,
  parameter int CYC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic [CYC_W-1:0]  cycle_num,
  input  logic              mt_tick,
  input  logic [SLOT_W-1:0] cfg_num_slots,
  input  logic [MT_W-1:0]   cfg_slot_len,
  input  logic [MT_W-1:0]   cfg_ap_off,
  output logic [SLOT_W-1:0] query_slot,
  output logic [CYC_W-1:0]  query_cycle,
  input  logic              query_pending,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              tx_strobe,
  output logic [SLOT_W-1:0] tx_slot_id,
  output logic              slot_bound,
  output logic              seg_done,
  output logic              cfg_err
);
  localparam int CMP_W = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

  seg_phase_e       phase;
  logic             running;
  logic             at_ap;
  logic             at_end;
  logic             last_slot;
  logic [CYC_W-1:0] cyc_q;
  logic [CMP_W-1:0] slot_ext_nxt;

  assign running      = (phase == PH_STATIC);
  assign cfg_err      = (cfg_ap_off >= cfg_slot_len);
  assign slot_ext_nxt = {1'b0, slot_cnt} + CMP_W'(1);
  assign last_slot    = slot_ext_nxt > {1'b0, cfg_num_slots};
  assign query_slot   = slot_cnt;
  assign query_cycle  = cyc_q;

  slot_timer #(.MT_W(MT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cycle_start),
    .enable   (running),
    .tick     (mt_tick),
    .slot_len (cfg_slot_len),
    .ap_off   (cfg_ap_off),
    .at_ap    (at_ap),
    .at_end   (at_end)
  );

  tx_gate #(.SLOT_W(SLOT_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cycle_start | at_end),
    .fire       (at_ap & query_pending & ~cfg_err),
    .slot_in    (slot_cnt),
    .tx_strobe  (tx_strobe),
    .tx_slot_id (tx_slot_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      slot_cnt   <= '0;
      cyc_q      <= '0;
      slot_bound <= 1'b0;
      seg_done   <= 1'b0;
    end else begin
      slot_bound <= 1'b0;
      seg_done   <= 1'b0;
      if (cycle_start) begin
        phase    <= PH_STATIC;
        slot_cnt <= SLOT_ONE;
        cyc_q    <= cycle_num;
      end else if (at_end) begin
        slot_cnt   <= slot_cnt + SLOT_ONE;
        slot_bound <= 1'b1;
        if (last_slot) begin
          phase    <= PH_FINISHED;
          seg_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/static_slot_seq_chk.sv
module static_slot_seq_chk #(
  parameter int SLOT_W = 6,
  parameter int CYC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cycle_start,
  input logic [SLOT_W-1:0] query_slot,
  input logic [SLOT_W-1:0] slot_cnt,
  input logic              tx_strobe,
  input logic [SLOT_W-1:0] tx_slot_id,
  input logic              slot_bound,
  input logic              seg_done,
  input logic              cfg_err
);
  logic [1:0] strobes_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || slot_bound || cycle_start) begin
      strobes_seen <= '0;
    end else if (tx_strobe && strobes_seen != 2'd3) begin
      strobes_seen <= strobes_seen + 2'd1;
    end
  end

  a_r8_one_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (strobes_seen == 2'd0));

  a_r7_err_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> !$past(cfg_err));

  a_r4_id_is_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (tx_slot_id == $past(query_slot)));

  a_r2_start_slot_one: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (slot_cnt == SLOT_W'(1)));

  a_r6_done_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> slot_bound);

  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bound |-> (slot_cnt == $past(slot_cnt) + SLOT_W'(1)));
endmodule

bind static_slot_seq static_slot_seq_chk #(.SLOT_W(SLOT_W), .CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_start (cycle_start),
  .query_slot  (query_slot),
  .slot_cnt    (slot_cnt),
  .tx_strobe   (tx_strobe),
  .tx_slot_id  (tx_slot_id),
  .slot_bound  (slot_bound),
  .seg_done    (seg_done),
  .cfg_err     (cfg_err)
);

// File: tb/static_slot_seq_tb.sv
module static_slot_seq_tb;
  localparam int SLOT_W = 6;
  localparam int MT_W   = 8;
  localparam int CYC_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cycle_start = 1'b0;
  logic [CYC_W-1:0]  cycle_num = '0;
  logic              mt_tick = 1'b0;
  logic [SLOT_W-1:0] cfg_num_slots = SLOT_W'(5);
  logic [MT_W-1:0]   cfg_slot_len = MT_W'(4);
  logic [MT_W-1:0]   cfg_ap_off = MT_W'(1);
  logic [SLOT_W-1:0] query_slot;
  logic [CYC_W-1:0]  query_cycle;
  logic              query_pending;
  logic [SLOT_W-1:0] slot_cnt;
  logic              tx_strobe;
  logic [SLOT_W-1:0] tx_slot_id;
  logic              slot_bound;
  logic              seg_done;
  logic              cfg_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Host table: slots 1, 2, 5 always owned; slot 3 only in cycle 2; slot 4 never.
  function automatic bit owned(int s, int c);
    return (s == 1) || (s == 2) || (s == 5) || (s == 3 && c == 2);
  endfunction

  always_comb query_pending = owned(int'(query_slot), int'(query_cycle));

  static_slot_seq #(.SLOT_W(SLOT_W), .MT_W(MT_W), .CYC_W(CYC_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .cycle_start (cycle_start), .cycle_num (cycle_num),
    .mt_tick (mt_tick), .cfg_num_slots (cfg_num_slots), .cfg_slot_len (cfg_slot_len),
    .cfg_ap_off (cfg_ap_off), .query_slot (query_slot), .query_cycle (query_cycle),
    .query_pending (query_pending), .slot_cnt (slot_cnt), .tx_strobe (tx_strobe),
    .tx_slot_id (tx_slot_id), .slot_bound (slot_bound), .seg_done (seg_done),
    .cfg_err (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) mt_tick = 1'b1;
    @(negedge clk) mt_tick = 1'b0;
  endtask

  // Start a cycle with a macrotick in the same clock, which must be ignored (R2).
  task automatic start_cycle(input int cyc);
    @(negedge clk);
    cycle_num   = CYC_W'(cyc);
    cycle_start = 1'b1;
    mt_tick     = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    mt_tick     = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_cnt == 0, "R1 slot_cnt", int'(slot_cnt), 0);
    chk(!tx_strobe && !slot_bound && !seg_done, "R1 pulses", int'(tx_strobe), 0);
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk(!tx_strobe && !slot_bound && !seg_done, "R1 idle tick pulses", int'(slot_bound), 0);
      chk(slot_cnt == 0, "R1 idle slot_cnt", int'(slot_cnt), 0);
    end
  endtask

  task automatic run_cycle(input int cyc, input int n, input int len, input int ap);
    bit err;
    cfg_num_slots = SLOT_W'(n);
    cfg_slot_len  = MT_W'(len);
    cfg_ap_off    = MT_W'(ap);
    err = (ap >= len);
    start_cycle(cyc);
    chk(slot_cnt == 1, "R2 slot_cnt after start", int'(slot_cnt), 1);
    chk(!slot_bound && !tx_strobe, "R2 same-clock tick ignored", int'(slot_bound), 0);
    chk(query_cycle == CYC_W'(cyc), "R9 query_cycle", int'(query_cycle), cyc);
    chk(query_slot == slot_cnt, "R9 query_slot", int'(query_slot), int'(slot_cnt));
    chk(cfg_err == err, "R7 cfg_err", int'(cfg_err), int'(err));
    for (int t = 1; t <= n * len + 2; t++) begin
      int s, pos, exp_slot;
      bit in_seg, exp_tx, exp_bound, exp_done;
      string rq;
      s        = (t - 1) / len + 1;
      pos      = (t - 1) % len;
      in_seg   = (t <= n * len);
      exp_bound = in_seg && (pos == len - 1);
      exp_done  = (t == n * len);
      exp_tx    = in_seg && (pos == ap) && !err && owned(s, cyc);
      exp_slot  = in_seg ? (t / len + 1) : (n + 1);
      do_tick();
      if (err) rq = "R7 tx";
      else if (!in_seg) rq = "R6 tx after done";
      else if (pos == ap && s == 3) rq = "R9 tx";
      else if (pos == ap && !owned(s, cyc)) rq = "R5 tx";
      else if (pos == ap) rq = "R4 tx";
      else rq = "R8 tx";
      chk(tx_strobe == exp_tx, rq, int'(tx_strobe), int'(exp_tx));
      if (exp_tx) chk(tx_slot_id == SLOT_W'(s), "R4 tx_slot_id", int'(tx_slot_id), s);
      chk(slot_bound == exp_bound, in_seg ? "R3 slot_bound" : "R6 bound after done",
          int'(slot_bound), int'(exp_bound));
      chk(seg_done == exp_done, "R6 seg_done", int'(seg_done), int'(exp_done));
      chk(slot_cnt == SLOT_W'(exp_slot), "R3 slot_cnt", int'(slot_cnt), exp_slot);
      @(negedge clk);
      chk(!tx_strobe && !slot_bound && !seg_done, "R8 pulse width", int'(tx_strobe), 0);
    end
  endtask

  task automatic test_restart();
    start_cycle(1);
    repeat (6) do_tick();
    run_cycle(1, 5, 4, 1);
  endtask

  initial begin
    test_reset();
    run_cycle(0, 5, 4, 1);
    run_cycle(2, 5, 3, 2);
    run_cycle(2, 5, 4, 0);
    run_cycle(0, 5, 3, 3);
    test_restart();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule